// File: doc/BRIEF.md
# Unipolar Resistive Cell Logic Sequencer

This block models one two-terminal unipolar resistive cell as a single stored bit, plus a controller that leaves any two-input Boolean function of operands `p` and `q` in that cell. The function is computed in place: the controller drives the cell's two terminals for one to three clock steps, and the cell's final state is the answer. Each terminal takes one of three drive levels: ground, a set-level pulse or a reset-level pulse. A high-resistance cell reads as 0 and a low-resistance cell reads as 1.

Each function runs in one of two modes, and the mode is derived from the function code. In set mode a logic 1 on a terminal is a set-level pulse. A step whose two terminals differ then drives the cell to 1. In reset mode a logic 1 is a reset-level pulse, and a step whose terminals differ drives the cell to 0. In both modes a step with equal terminals leaves the cell unchanged. Every function except the two constants first puts the cell into a known state. Set-mode functions clear it to 0, and reset-mode functions preset it to 1. Two further steps then apply the operands. A host pulses `start` with a code and the operands, waits for `done`, and then reads `result` and `cycles`. A separate read strobe returns the stored bit at any time.

Top module: `unipolar_logic_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rd_vld` and `cycles` are 0, and the stored cell state is 0, so a read strobe returns 0.
- R2: The 4-bit `func` is the function's truth table. When `done` is high, `result` equals `func[{p,q}]`, where bit index 2*p+q selects the output.
- R3: The number of drive steps, reported on `cycles` with `done`, is 1 for codes 0 and 15. It is 2 for codes 3, 5, 6, 9, 10 and 12. It is 3 for every other code.
- R4: `busy` rises in the cycle after an accepted `start` and stays high for exactly `cycles` clocks. `done` is high for one clock in the cycle right after the last step. `busy` and `done` are never high together.
- R5: Every code other than 0 and 15 begins with an initialise step. The code's mode decides the state it leaves: 0 for set-mode codes and 1 for reset-mode codes 1, 2, 4, 8 and 9. Because of this step, `result` does not depend on what the cell held before.
- R6: Code 15 (constant 1) and code 0 (constant 0) use a single step with no initialise step. They give 1 and 0 whatever the cell held before.
- R7: A `start` that arrives while `busy` is high is ignored. The running operation finishes with its own code and operands, and no further operation follows.
- R8: Raising `rd_en` for one clock makes `rd_vld` high one clock later, with `rd_bit` equal to the stored state. A read does not change the stored state.
- R9: A step with equal terminal drives holds the cell. A set-level pulse against ground sets the cell to 1. A reset-level pulse against ground, or a set-level pulse against a reset-level pulse, clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| func | input | 4 | Truth-table code of the function |
| p | input | 1 | First operand |
| q | input | 1 | Second operand |
| rd_en | input | 1 | One-cycle read strobe for the stored bit |
| busy | output | 1 | Drive steps in progress |
| done | output | 1 | One-clock pulse after the last step |
| result | output | 1 | Stored cell state; the function value when `done` is high |
| cycles | output | 2 | Steps used by the operation just finished |
| rd_vld | output | 1 | Read data valid |
| rd_bit | output | 1 | Stored state captured by the read |

## Verification
The assertions check the cell's update rule on every cycle: equal drives hold the state, and each unequal drive pair forces the state it should. They also check that `done` lasts one clock and never overlaps `busy`, that `cycles` stays between one and three, and that the latched code cannot change during a run. Only the bench scenarios can show that the step sequences compute the right function. The bench sweeps all sixteen codes against all four operand pairs, starting from both prior cell states. It also confirms that the busy span matches the step count, that a start arriving mid-run is ignored, and that a read leaves the stored bit unchanged.

// File: rtl/ulc_pkg.sv
package ulc_pkg;

  localparam int FUNC_W    = 4;
  localparam int MAX_STEPS = 3;
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);

  typedef enum logic [1:0] {
    LV_GND = 2'd0,
    LV_SET = 2'd1,
    LV_RST = 2'd2
  } level_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_ONE  = 2'd1,
    SRC_P    = 2'd2,
    SRC_Q    = 2'd3
  } src_e;

  typedef struct packed {
    src_e t1;
    src_e t2;
  } step_t;

  typedef struct packed {
    logic             rst_mode;
    logic             has_init;
    logic [CNT_W-1:0] nsteps;
    step_t            op_a;
    step_t            op_b;
  } plan_t;

endpackage

// File: rtl/ulc_decode.sv
module ulc_decode
  import ulc_pkg::*;
(
  input  logic [FUNC_W-1:0] code,
  output plan_t             plan
);

  step_t pat_a;
  step_t pat_b;
  logic  two_ops;

  always_comb begin
    pat_a   = '{t1: SRC_ONE, t2: SRC_ZERO};
    pat_b   = '{t1: SRC_ONE, t2: SRC_ZERO};
    two_ops = 1'b0;
    unique case (code)
      4'd0, 4'd15: begin
        pat_a = '{t1: SRC_ONE, t2: SRC_ZERO};
      end
      4'd12: pat_a = '{t1: SRC_P, t2: SRC_ZERO};
      4'd10: pat_a = '{t1: SRC_Q, t2: SRC_ZERO};
      4'd3:  pat_a = '{t1: SRC_P, t2: SRC_ONE};
      4'd5:  pat_a = '{t1: SRC_Q, t2: SRC_ONE};
      4'd6, 4'd9: pat_a = '{t1: SRC_P, t2: SRC_Q};
      4'd14, 4'd1: begin
        pat_a = '{t1: SRC_P, t2: SRC_ZERO};
        pat_b = '{t1: SRC_Q, t2: SRC_ZERO};
        two_ops = 1'b1;
      end
      4'd7, 4'd8: begin
        pat_a = '{t1: SRC_P, t2: SRC_ONE};
        pat_b = '{t1: SRC_Q, t2: SRC_ONE};
        two_ops = 1'b1;
      end
      4'd11, 4'd4: begin
        pat_a = '{t1: SRC_P, t2: SRC_ONE};
        pat_b = '{t1: SRC_Q, t2: SRC_ZERO};
        two_ops = 1'b1;
      end
      default: begin
        pat_a = '{t1: SRC_P, t2: SRC_ZERO};
        pat_b = '{t1: SRC_Q, t2: SRC_ONE};
        two_ops = 1'b1;
      end
    endcase
  end

  always_comb begin
    plan.rst_mode = (code == 4'd0) || (code == 4'd1) || (code == 4'd2) ||
                    (code == 4'd4) || (code == 4'd8) || (code == 4'd9);
    plan.has_init = (code != 4'd0) && (code != 4'd15);
    plan.op_a     = pat_a;
    plan.op_b     = pat_b;
    if (!plan.has_init)
      plan.nsteps = CNT_W'(1);
    else if (two_ops)
      plan.nsteps = CNT_W'(3);
    else
      plan.nsteps = CNT_W'(2);
  end

endmodule

// File: rtl/ulc_cell.sv
module ulc_cell
  import ulc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  level_e t1,
  input  level_e t2,
  input  logic   rd_en,
  output logic   state,
  output logic   rd_vld,
  output logic   rd_bit
);

  logic state_q, state_d;
  logic rd_vld_q, rd_bit_q, rd_bit_d;

  always_comb begin
    if (t1 == t2)
      state_d = state_q;
    else if ((t1 == LV_SET && t2 == LV_GND) || (t2 == LV_SET && t1 == LV_GND))
      state_d = 1'b1;
    else
      state_d = 1'b0;
    rd_bit_d = rd_en ? state_q : rd_bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= 1'b0;
      rd_vld_q <= 1'b0;
      rd_bit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rd_vld_q <= rd_en;
      rd_bit_q <= rd_bit_d;
    end
  end

  assign state  = state_q;
  assign rd_vld = rd_vld_q;
  assign rd_bit = rd_bit_q;

  // R9
  hold_on_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t1 == t2) |=> $stable(state_q));

  // R9
  set_vs_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((t1 == LV_SET && t2 == LV_GND) || (t1 == LV_GND && t2 == LV_SET)) |=> state_q);

  // R9
  rst_vs_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((t1 == LV_RST && t2 == LV_GND) || (t1 == LV_GND && t2 == LV_RST)) |=> !state_q);

endmodule

// File: rtl/ulc_seq.sv
module ulc_seq
  import ulc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FUNC_W-1:0] func,
  input  logic              p,
  input  logic              q,
  output level_e            t1,
  output level_e            t2,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  cycles
);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  step_q, step_d;
  logic [CNT_W-1:0]  cyc_q, cyc_d;
  logic [FUNC_W-1:0] code_q, code_d;
  logic              p_q, p_d, q_q, q_d;
  logic              last;
  plan_t             plan;
  step_t             cur;
  logic              is_init;
  level_e            active;

  ulc_decode u_dec (.code(code_q), .plan(plan));

  function automatic level_e map_src(src_e s, logic pv, logic qv, level_e act);
    case (s)
      SRC_ONE: return act;
      SRC_P:   return pv ? act : LV_GND;
      SRC_Q:   return qv ? act : LV_GND;
      default: return LV_GND;
    endcase
  endfunction

  assign last = (step_q == plan.nsteps - CNT_W'(1));

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    step_d = step_q;
    cyc_d  = cyc_q;
    code_d = code_q;
    p_d    = p_q;
    q_d    = q_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        step_d = '0;
        code_d = func;
        p_d    = p;
        q_d    = q;
      end
    end else if (last) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      cyc_d  = plan.nsteps;
    end else begin
      step_d = step_q + CNT_W'(1);
    end
  end

  always_comb begin
    active  = plan.rst_mode ? LV_RST : LV_SET;
    is_init = plan.has_init && (step_q == '0);
    cur     = (plan.has_init && step_q == CNT_W'(2)) ? plan.op_b : plan.op_a;
    if (!busy_q) begin
      t1 = LV_GND;
      t2 = LV_GND;
    end else if (is_init) begin
      t1 = plan.rst_mode ? LV_SET : LV_RST;
      t2 = LV_GND;
    end else begin
      t1 = map_src(cur.t1, p_q, q_q, active);
      t2 = map_src(cur.t2, p_q, q_q, active);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      cyc_q  <= '0;
      code_q <= '0;
      p_q    <= 1'b0;
      q_q    <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      step_q <= step_d;
      cyc_q  <= cyc_d;
      code_q <= code_d;
      p_q    <= p_d;
      q_q    <= q_d;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign cycles = cyc_q;

  // R4
  done_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  // R3
  cycles_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cyc_q >= CNT_W'(1) && cyc_q <= CNT_W'(MAX_STEPS)));

  // R7
  code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> ($stable(code_q) && $stable(p_q) && $stable(q_q)));

endmodule

// File: rtl/unipolar_logic_seq.sv
module unipolar_logic_seq
  import ulc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FUNC_W-1:0] func,
  input  logic              p,
  input  logic              q,
  input  logic              rd_en,
  output logic              busy,
  output logic              done,
  output logic              result,
  output logic [CNT_W-1:0]  cycles,
  output logic              rd_vld,
  output logic              rd_bit
);

  level_e drv_t1;
  level_e drv_t2;

  ulc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func), .p(p), .q(q),
    .t1(drv_t1), .t2(drv_t2), .busy(busy), .done(done), .cycles(cycles)
  );

  ulc_cell u_cell (
    .clk(clk), .rst_n(rst_n), .t1(drv_t1), .t2(drv_t2), .rd_en(rd_en),
    .state(result), .rd_vld(rd_vld), .rd_bit(rd_bit)
  );

endmodule

// File: tb/sim_unipolar_logic_seq.sv
module sim_unipolar_logic_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] func = 4'd0;
  logic       p = 1'b0;
  logic       q = 1'b0;
  logic       rd_en = 1'b0;
  logic       busy, done, result, rd_vld, rd_bit;
  logic [1:0] cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  unipolar_logic_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func), .p(p), .q(q),
    .rd_en(rd_en), .busy(busy), .done(done), .result(result),
    .cycles(cycles), .rd_vld(rd_vld), .rd_bit(rd_bit)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_steps(int c);
    if (c == 0 || c == 15) return 1;
    if (c == 3 || c == 5 || c == 6 || c == 9 || c == 10 || c == 12) return 2;
    return 3;
  endfunction

  int r_res, r_cyc, r_busy;

  task automatic run_op(int c, bit pv, bit qv, int inject_at);
    int guard;
    @(negedge clk);
    func = 4'(c); p = pv; q = qv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_busy = 0; guard = 0;
    while (!done && guard < 20) begin
      if (busy) r_busy++;
      if (r_busy == inject_at) begin
        func = 4'd15; p = ~pv; q = ~qv; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    if (!done) check("R4 done never seen", 0, 1);
    check("R4 busy low with done", int'(busy), 0);
    r_res = int'(result);
    r_cyc = int'(cycles);
  endtask

  task automatic do_read(output int bitv, output int vld);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    bitv = int'(rd_bit);
    vld  = int'(rd_vld);
  endtask

  initial begin
    int rb, rv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 cycles", int'(cycles), 0);
    check("R1 rd_vld", int'(rd_vld), 0);
    rst_n = 1'b1;
    do_read(rb, rv);
    check("R1 read valid", rv, 1);
    check("R1 cell state", rb, 0);

    // R2 R3 R4 R5 R6: every code, operand pair and prior state
    for (int c = 0; c < 16; c++) begin
      for (int pq = 0; pq < 4; pq++) begin
        for (int prior = 0; prior < 2; prior++) begin
          run_op(prior ? 15 : 0, 1'b0, 1'b0, -1);
          check("R6 constant prior", r_res, prior);
          run_op(c, pq[1], pq[0], -1);
          check("R2 R5 result", r_res, int'(c[pq]));
          check("R3 cycles", r_cyc, exp_steps(c));
          check("R4 busy span", r_busy, exp_steps(c));
        end
      end
    end

    // R9: equal terminals hold the cleared cell (xor of 1,1 from prior 1)
    run_op(15, 1'b0, 1'b0, -1);
    run_op(6, 1'b1, 1'b1, -1);
    check("R9 equal drive holds", r_res, 0);
    // R9: reset pulse against ground clears a preset cell (and 1,0 step)
    run_op(8, 1'b1, 1'b0, -1);
    check("R9 reset vs ground", r_res, 0);

    // R7: start while busy is ignored
    run_op(7, 1'b1, 1'b1, 2);
    check("R7 original result", r_res, 0);
    check("R7 original cycles", r_cyc, 3);
    check("R7 busy span", r_busy, 3);
    repeat (3) begin
      @(negedge clk);
      check("R7 no second op busy", int'(busy), 0);
      check("R7 no second op done", int'(done), 0);
    end

    // R8: reads return state and do not change it
    run_op(15, 1'b0, 1'b0, -1);
    do_read(rb, rv);
    check("R8 read valid", rv, 1);
    check("R8 read bit 1", rb, 1);
    do_read(rb, rv);
    check("R8 second read bit", rb, 1);
    check("R8 state after reads", int'(result), 1);
    @(negedge clk);
    check("R8 valid drops", int'(rd_vld), 0);
    run_op(0, 1'b0, 1'b0, -1);
    do_read(rb, rv);
    check("R8 read bit 0", rb, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule